// File: doc/BRIEF.md
# Stereo Serial Audio Master Port

This block is a memory-mapped two-channel serial audio port that always owns the serial bus. It runs from a master clock at 256 times the sample rate. It divides that clock by four to produce the bit clock, which gives 64 bit clocks per frame and a 32-bit slot for each channel. Samples that software writes to the data port are queued in a small transmit FIFO and shifted out one slot at a time, left channel first. Bits from the data pin, or from the block's own transmit stream when loopback is selected, are assembled into samples and queued in a receive FIFO.

One register holds the format fields, the status flags and the per-direction path enables. The framing can be standard I2S, where the MSB lags word-select by one bit, left-justified, or right-justified. The sample width can be 8, 16, 18, 20 or 24 bits. Bit-clock and word-select polarity can each be inverted, and the data pin can be turned round to act as an input. A second register holds a disable bit and a clock-enable bit. Software writes both bits set and then clock-enable alone to start the port. Setting the disable bit parks the serial logic again.

The bus interface is single-cycle. `bus_rdata` is combinational on `bus_addr`. A write, or a read of the data port, takes effect on the clock edge while `bus_sel` is high.

Top module: `i2s_master_ctl`

## Requirements
- R1: After reset the configuration word (offset 0x4) reads 0x0030_0010: width 16, standard framing, both paths off, no flags, transmit-empty (bit 20) and transmit-room (bit 21) set. The enable word (offset 0x8) reads 2. `sck_o`=0, `ws_o`=1, `sd_o`=0, `sd_oe`=1.
- R2: While running, rising edges of the effective bit clock come every 4 master clocks. The effective word-select is 0 for the first 32 bits of each 64-bit frame (left) and 1 for the last 32 (right).
- R3: Framing is set by configuration bits [8:7]. With 0 (standard), sample bit W-1 is sent in slot bit 1. With 1 (left-justified), it is sent in slot bit 0. With 2 (right-justified), sample bit 0 is sent in slot bit 31. Every other slot bit is 0.
- R4: Configuration bits [4:0] hold the width. Values 8, 16, 18, 20 and 24 are stored. Any other value, and framing value 3, leaves the stored field unchanged.
- R5: Bit 12 inverts the `sck_o` pin and bit 9 inverts the `ws_o` pin. The two are independent and neither moves the data timing.
- R6: With loopback (bit 10) set, the receiver takes the transmit bit stream and ignores `sd_i`. With loopback clear, it samples `sd_i` on the effective rising bit-clock edge.
- R7: Bit 11 set drives `sd_oe` low.
- R8: A write to offset 0x0 pushes the low 24 bits into the 8-entry transmit FIFO. A write while full is dropped and sets sticky bit 24. Bit 19 reports full.
- R9: At each slot start with the transmit path enabled (bit 6) and the FIFO empty, the slot carries zero and sticky bit 25 is set.
- R10: With the receive path enabled (bit 5), one sample per slot is pushed into the 8-entry receive FIFO, zero-extended. A push while full is dropped and sets bit 22. A read of offset 0x0 pops. A read while empty returns 0 and sets bit 23. Bit 18 reports not-empty and bit 17 reports full.
- R11: Writing 1 to any of bits 25..22 clears that flag. Writing 0 leaves it.
- R12: Enable bit 1 set holds the serial logic parked: `sck_o` at its idle level and raw word-select high. Bit 0 clear with bit 1 clear freezes the bit clock and word-select. After writing 3 and then 1, one right-slot bit passes before the first left slot.
- R13: With the transmit path disabled, slots carry zero, the FIFO is not popped and no underflow is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 256x sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset: 0x0 data, 0x4 configuration, 0x8 enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word-select |
| sd_o | output | 1 | Serial data out |
| sd_oe | output | 1 | Output enable for the data pin |
| sd_i | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: divide-by-four bit clock, 32-bit slots and 8-entry FIFOs. A whole frame therefore lasts 256 master clocks. This lets the bench sweep every framing value against every legal width, with the clock and word-select inversion pairs rotating through the sweep. Each combination runs two full frames, which are decoded bit by bit and also returned through loopback. The shallow FIFOs let both overflow paths, the underflow paths and the W1C clearing be reached within a few hundred cycles each.

// File: rtl/i2s_ctl_pkg.sv
package i2s_ctl_pkg;

  localparam int SMP_W     = 24;
  localparam int SLOT_BITS = 32;

  // configuration word bit positions
  localparam int B_TX_UF   = 25;
  localparam int B_TX_OF   = 24;
  localparam int B_RX_UF   = 23;
  localparam int B_RX_OF   = 22;
  localparam int B_SCK_INV = 12;
  localparam int B_PIN_IN  = 11;
  localparam int B_LOOP    = 10;
  localparam int B_WS_INV  = 9;
  localparam int B_TX_EN   = 6;
  localparam int B_RX_EN   = 5;

  typedef enum logic [1:0] {
    FMT_STD   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_RSVD  = 2'd3
  } frame_fmt_e;

  function automatic logic width_ok(input logic [4:0] w);
    return w inside {5'd8, 5'd16, 5'd18, 5'd20, 5'd24};
  endfunction

  // slot bit that carries the sample MSB
  function automatic int msb_slot_pos(input frame_fmt_e f, input int w);
    case (f)
      FMT_LEFT:  return 0;
      FMT_RIGHT: return SLOT_BITS - w;
      default:   return 1;
    endcase
  endfunction

  function automatic logic in_window(input int b, input int first, input int w);
    return (b >= first) && (b < first + w);
  endfunction

  function automatic logic slot_bit(input logic [SMP_W-1:0] s, input int b,
                                    input int first, input int w);
    logic [SMP_W-1:0] t;
    if (!in_window(b, first, w)) return 1'b0;
    t = s >> (w - 1 - (b - first));
    return t[0];
  endfunction

endpackage

// File: rtl/i2s_fifo.sv
module i2s_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic do_push, do_pop;

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/i2s_serial_engine.sv
module i2s_serial_engine
  import i2s_ctl_pkg::*;
#(
  parameter int MCLK_DIV = 4,
  parameter int SW       = SMP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          hold,
  input  frame_fmt_e    fmt,
  input  logic [4:0]    width,
  input  logic          loopback,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic [SW-1:0] tx_data,
  input  logic          tx_empty,
  input  logic          sd_i,
  output logic          tx_pop,
  output logic          tx_uf_evt,
  output logic          rx_push,
  output logic [SW-1:0] rx_data,
  output logic          bclk_raw,
  output logic          ws_raw,
  output logic          sd_raw
);
  localparam int DCW        = $clog2(MCLK_DIV);
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int BPW        = $clog2(FRAME_BITS);
  localparam int SLW        = $clog2(SLOT_BITS);

  logic [DCW-1:0] div_q;
  logic [BPW-1:0] pos_q;
  logic [SW-1:0]  cur_q, acc_q;
  logic           arm_q;

  logic [SLW-1:0] sbit;
  logic tick, bit_end, sample_pt, slot_end, win, tx_bit, rx_bit;
  int   first;

  assign sbit      = pos_q[SLW-1:0];
  assign tick      = run && !hold;
  assign bit_end   = tick && (div_q == DCW'(MCLK_DIV-1));
  assign sample_pt = tick && (div_q == DCW'(MCLK_DIV/2));
  assign slot_end  = bit_end && (&sbit);

  always_comb begin
    first  = msb_slot_pos(fmt, int'(width));
    win    = in_window(int'(sbit), first, int'(width));
    tx_bit = slot_bit(cur_q, int'(sbit), first, int'(width));
    rx_bit = loopback ? tx_bit : sd_i;
  end

  assign tx_pop    = slot_end && tx_en && !tx_empty;
  assign tx_uf_evt = slot_end && tx_en && tx_empty;
  assign rx_push   = slot_end && arm_q && rx_en;
  assign rx_data   = acc_q;
  assign bclk_raw  = (div_q >= DCW'(MCLK_DIV/2));
  assign ws_raw    = pos_q[BPW-1];
  assign sd_raw    = tx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pos_q <= '1;
      cur_q <= '0;
      acc_q <= '0;
      arm_q <= 1'b0;
    end else if (hold) begin
      div_q <= '0;
      pos_q <= '1;
      cur_q <= '0;
      acc_q <= '0;
      arm_q <= 1'b0;
    end else if (tick) begin
      div_q <= bit_end ? '0 : div_q + 1'b1;
      if (bit_end) pos_q <= pos_q + 1'b1;
      if (slot_end) begin
        cur_q <= tx_pop ? tx_data : '0;
        acc_q <= '0;
        arm_q <= 1'b1;
      end else if (sample_pt && win) begin
        acc_q <= {acc_q[SW-2:0], rx_bit};
      end
    end
  end
endmodule

// File: rtl/i2s_master_ctl.sv
module i2s_master_ctl
  import i2s_ctl_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int BUS_W      = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int MCLK_DIV   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              sck_o,
  output logic              ws_o,
  output logic              sd_o,
  output logic              sd_oe,
  input  logic              sd_i
);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_EN   = ADDR_W'(8);

  // configuration fields
  logic       cfg_sck_inv, cfg_pin_in, cfg_loop, cfg_ws_inv, cfg_tx_en, cfg_rx_en;
  frame_fmt_e cfg_fmt;
  logic [4:0] cfg_width;
  logic       flag_tx_uf, flag_tx_of, flag_rx_uf, flag_rx_of;
  logic [1:0] en_q;

  // named internal events
  logic wr_data, wr_cfg, wr_en, rd_data;
  logic tx_push, tx_pop, tx_full, tx_empty, tx_uf_evt;
  logic rx_push, rx_pop, rx_full, rx_empty;
  logic [SMP_W-1:0] tx_head, rx_head, rx_in;
  logic bclk_raw, ws_raw, sd_raw;
  logic [BUS_W-1:0] cfg_word;
  logic unused_wdata;

  assign unused_wdata = ^{bus_wdata[BUS_W-1:26], bus_wdata[21:13]};

  assign wr_data = bus_sel &&  bus_wr && (bus_addr == OFS_DATA);
  assign wr_cfg  = bus_sel &&  bus_wr && (bus_addr == OFS_CFG);
  assign wr_en   = bus_sel &&  bus_wr && (bus_addr == OFS_EN);
  assign rd_data = bus_sel && !bus_wr && (bus_addr == OFS_DATA);
  assign tx_push = wr_data;
  assign rx_pop  = rd_data;

  i2s_fifo #(.W(SMP_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata[SMP_W-1:0]),
    .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
  );

  i2s_fifo #(.W(SMP_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_in),
    .pop(rx_pop), .rdata(rx_head), .full(rx_full), .empty(rx_empty)
  );

  i2s_serial_engine #(.MCLK_DIV(MCLK_DIV), .SW(SMP_W)) engine_i (
    .clk(clk), .rst_n(rst_n), .run(en_q[0]), .hold(en_q[1]),
    .fmt(cfg_fmt), .width(cfg_width), .loopback(cfg_loop),
    .tx_en(cfg_tx_en), .rx_en(cfg_rx_en), .tx_data(tx_head), .tx_empty(tx_empty),
    .sd_i(sd_i), .tx_pop(tx_pop), .tx_uf_evt(tx_uf_evt), .rx_push(rx_push),
    .rx_data(rx_in), .bclk_raw(bclk_raw), .ws_raw(ws_raw), .sd_raw(sd_raw)
  );

  // sticky flag update: set wins over a simultaneous clear
  function automatic logic sticky(input logic cur, input logic clr, input logic set);
    return (cur && !clr) || set;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_sck_inv <= 1'b0;
      cfg_pin_in  <= 1'b0;
      cfg_loop    <= 1'b0;
      cfg_ws_inv  <= 1'b0;
      cfg_tx_en   <= 1'b0;
      cfg_rx_en   <= 1'b0;
      cfg_fmt     <= FMT_STD;
      cfg_width   <= 5'd16;
      flag_tx_uf  <= 1'b0;
      flag_tx_of  <= 1'b0;
      flag_rx_uf  <= 1'b0;
      flag_rx_of  <= 1'b0;
      en_q        <= 2'b10;
    end else begin
      if (wr_cfg) begin
        cfg_sck_inv <= bus_wdata[B_SCK_INV];
        cfg_pin_in  <= bus_wdata[B_PIN_IN];
        cfg_loop    <= bus_wdata[B_LOOP];
        cfg_ws_inv  <= bus_wdata[B_WS_INV];
        cfg_tx_en   <= bus_wdata[B_TX_EN];
        cfg_rx_en   <= bus_wdata[B_RX_EN];
        if (bus_wdata[8:7] != 2'd3) cfg_fmt <= frame_fmt_e'(bus_wdata[8:7]);
        if (width_ok(bus_wdata[4:0])) cfg_width <= bus_wdata[4:0];
      end
      if (wr_en) en_q <= bus_wdata[1:0];
      flag_tx_uf <= sticky(flag_tx_uf, wr_cfg && bus_wdata[B_TX_UF], tx_uf_evt);
      flag_tx_of <= sticky(flag_tx_of, wr_cfg && bus_wdata[B_TX_OF], tx_push && tx_full);
      flag_rx_uf <= sticky(flag_rx_uf, wr_cfg && bus_wdata[B_RX_UF], rx_pop && rx_empty);
      flag_rx_of <= sticky(flag_rx_of, wr_cfg && bus_wdata[B_RX_OF], rx_push && rx_full);
    end
  end

  assign cfg_word = {6'b0, flag_tx_uf, flag_tx_of, flag_rx_uf, flag_rx_of,
                     !tx_full, tx_empty, tx_full, !rx_empty, rx_full, 4'b0,
                     cfg_sck_inv, cfg_pin_in, cfg_loop, cfg_ws_inv, cfg_fmt,
                     cfg_tx_en, cfg_rx_en, cfg_width};

  always_comb begin
    case (bus_addr)
      OFS_DATA: bus_rdata = rx_empty ? '0 : {{(BUS_W-SMP_W){1'b0}}, rx_head};
      OFS_CFG:  bus_rdata = cfg_word;
      OFS_EN:   bus_rdata = {{(BUS_W-2){1'b0}}, en_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign sck_o = bclk_raw ^ cfg_sck_inv;
  assign ws_o  = ws_raw ^ cfg_ws_inv;
  assign sd_o  = sd_raw;
  assign sd_oe = !cfg_pin_in;
endmodule

// File: rtl/i2s_master_ctl_chk.sv
module i2s_master_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_pop,
  input logic       tx_empty,
  input logic       tx_uf_evt,
  input logic       tx_uf_flag,
  input logic       tx_push,
  input logic       tx_full,
  input logic       tx_of_flag,
  input logic       rx_push,
  input logic       rx_full,
  input logic       rx_of_flag,
  input logic       tx_en,
  input logic [1:0] en_q,
  input logic       bclk_raw,
  input logic       sck_o,
  input logic       sck_inv
);
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty); // R9
  AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_uf_evt |=> tx_uf_flag); // R9
  AST_TX_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_full) |=> tx_of_flag); // R8
  AST_RX_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> rx_of_flag); // R10
  AST_TX_IDLE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_pop); // R13
  AST_CLOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 2'b00) |=> $stable(bclk_raw)); // R12
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[1] |=> (sck_o == sck_inv)); // R12
endmodule

bind i2s_master_ctl i2s_master_ctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tx_pop(tx_pop), .tx_empty(tx_empty),
  .tx_uf_evt(tx_uf_evt), .tx_uf_flag(flag_tx_uf), .tx_push(tx_push),
  .tx_full(tx_full), .tx_of_flag(flag_tx_of), .rx_push(rx_push),
  .rx_full(rx_full), .rx_of_flag(flag_rx_of), .tx_en(cfg_tx_en),
  .en_q(en_q), .bclk_raw(bclk_raw), .sck_o(sck_o), .sck_inv(cfg_sck_inv)
);

// File: tb/i2s_master_ctl_tb.sv
module i2s_master_ctl_tb_top;
  localparam logic [3:0] A_DATA = 4'h0;
  localparam logic [3:0] A_CFG  = 4'h4;
  localparam logic [3:0] A_EN   = 4'h8;
  localparam logic [31:0] W1C_ALL = 32'h03C0_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic sck_o, ws_o, sd_o, sd_oe;
  logic sd_i = 1'b1;

  int n_checks = 0;
  int n_fail = 0;
  logic cap_sd [0:511];
  logic cap_ws [0:511];
  int per_err;

  always #5 clk = ~clk;

  i2s_master_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o), .sd_oe(sd_oe), .sd_i(sd_i)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic logic [31:0] mk_cfg(bit ck, bit pin, bit lb, bit wsi, int fmt,
                                         bit txe, bit rxe, int w);
    return (32'(ck) << 12) | (32'(pin) << 11) | (32'(lb) << 10) | (32'(wsi) << 9) |
           (32'(fmt) << 7) | (32'(txe) << 6) | (32'(rxe) << 5) | 32'(w);
  endfunction

  // independent restatement of slot placement, counted from the sample LSB
  function automatic logic exp_bit(int fmt, int w, logic [31:0] s, int b);
    int k;
    case (fmt)
      2:       k = 31 - b;
      1:       k = w - 1 - b;
      default: k = w - b;
    endcase
    if (k < 0 || k >= w) return 1'b0;
    return s[k];
  endfunction

  task automatic capture(input int n, input logic ck, input logic wsi);
    int got = 0;
    int since = 0;
    logic prev;
    prev = sck_o ^ ck;
    per_err = 0;
    while (got < n) begin
      @(negedge clk);
      since++;
      if (!prev && (sck_o ^ ck)) begin
        cap_sd[got] = sd_o;
        cap_ws[got] = ws_o ^ wsi;
        if (got > 0 && since != 4) per_err++;
        since = 0;
        got++;
      end
      prev = sck_o ^ ck;
    end
  endtask

  task automatic drain_rx();
    logic [31:0] d;
    for (int i = 0; i < 9; i++) bus_read(A_DATA, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, smp [4];
    int wtab [5] = '{8, 16, 18, 20, 24};
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(A_CFG, d);
    chk(d == 32'h0030_0010, "R1 cfg reset", d, 32'h0030_0010);
    bus_read(A_EN, d);
    chk(d == 32'd2, "R1 enable reset", d, 32'd2);
    chk({sck_o, ws_o, sd_o, sd_oe} == 4'b0101, "R1 pins reset",
        {28'd0, sck_o, ws_o, sd_o, sd_oe}, 32'h5);

    // R4 field legality
    bus_write(A_CFG, mk_cfg(0, 0, 0, 0, 1, 0, 0, 20));
    bus_read(A_CFG, d);
    chk(d[8:0] == 9'h094, "R4 legal width/format stored", {23'd0, d[8:0]}, 32'h94);
    bus_write(A_CFG, mk_cfg(0, 0, 0, 0, 3, 0, 0, 12));
    bus_read(A_CFG, d);
    chk(d[8:0] == 9'h094, "R4 illegal width/format ignored", {23'd0, d[8:0]}, 32'h94);
    bus_write(A_CFG, mk_cfg(0, 0, 0, 0, 0, 0, 0, 0));
    bus_read(A_CFG, d);
    chk(d[4:0] == 5'd20, "R4 width zero ignored", {27'd0, d[4:0]}, 32'd20);

    // R2 R3 R5 R6 R9 R12 sweep over framing and width
    c = 0;
    for (int f = 0; f < 3; f++) begin
      for (int wi = 0; wi < 5; wi++) begin
        int w = wtab[wi];
        logic ck = c[0];
        logic wsi = c[1];
        logic [31:0] mask = (32'd1 << w) - 1;
        int ws_bad = 0;
        bus_write(A_EN, 32'd2);
        drain_rx();
        bus_write(A_CFG, mk_cfg(ck, 0, 1, wsi, f, 1, 1, w) | W1C_ALL);
        @(negedge clk);
        chk(sck_o == ck && ws_o == !wsi, "R5 idle pin polarity",
            {30'd0, sck_o, ws_o}, {30'd0, ck, !wsi});
        for (int k = 0; k < 4; k++) begin
          smp[k] = ((32'h9E3779B9 * 32'(c * 4 + k + 1)) >> 3) & mask;
          bus_write(A_DATA, smp[k]);
        end
        bus_write(A_EN, 32'd3);
        bus_write(A_EN, 32'd1);
        capture(129, ck, wsi);
        chk(per_err == 0, "R2 bit clock period", 32'(per_err), 32'd0);
        chk(cap_ws[0] == 1'b1, "R12 lead-in bit in right slot", {31'd0, cap_ws[0]}, 32'd1);
        for (int k = 1; k < 129; k++)
          if (cap_ws[k] != (((k - 1) % 64) >= 32)) ws_bad++;
        chk(ws_bad == 0, "R2 word-select halves", 32'(ws_bad), 32'd0);
        for (int s = 0; s < 4; s++) begin
          int bad = 0;
          for (int b = 0; b < 32; b++)
            if (cap_sd[1 + s * 32 + b] != exp_bit(f, w, smp[s], b)) bad++;
          chk(bad == 0, $sformatf("R3 slot bits fmt=%0d w=%0d slot=%0d", f, w, s),
              32'(bad), 32'd0);
        end
        repeat (6) @(negedge clk);
        bus_read(A_CFG, d);
        chk(d[25] == 1'b1, "R9 underflow after queue ran dry", {31'd0, d[25]}, 32'd1);
        bus_write(A_EN, 32'd2);
        for (int k = 0; k < 4; k++) begin
          bus_read(A_DATA, d);
          chk(d == smp[k], "R6 loopback receive", d, smp[k]);
        end
        c++;
      end
    end

    // R7 R8 R11 with transmit path off and pin turned round
    bus_write(A_EN, 32'd2);
    drain_rx();
    bus_write(A_CFG, mk_cfg(0, 1, 0, 0, 1, 0, 1, 8) | W1C_ALL);
    @(negedge clk);
    chk(sd_oe == 1'b0, "R7 data pin input", {31'd0, sd_oe}, 32'd0);
    for (int k = 0; k < 9; k++) bus_write(A_DATA, 32'h5A + 32'(k));
    bus_read(A_CFG, d);
    chk(d[24] && d[19], "R8 tx overflow and full", {30'd0, d[24], d[19]}, 32'd3);
    bus_write(A_CFG, mk_cfg(0, 1, 0, 0, 1, 0, 1, 8) | (32'd1 << 24));
    bus_read(A_CFG, d);
    chk(!d[24] && d[19], "R11 W1C clears tx overflow", {30'd0, d[24], d[19]}, 32'd1);

    // R13 R10 R6: receive sd_i high, transmit idle
    sd_i = 1'b1;
    bus_write(A_EN, 32'd3);
    bus_write(A_EN, 32'd1);
    capture(321, 1'b0, 1'b0);
    begin
      int ones = 0;
      for (int k = 0; k < 321; k++) if (cap_sd[k]) ones++;
      chk(ones == 0, "R13 idle transmit sends zero", 32'(ones), 32'd0);
    end
    repeat (6) @(negedge clk);
    bus_read(A_CFG, d);
    chk(!d[25] && d[19], "R13 no underflow and no pop", {30'd0, d[25], d[19]}, 32'd1);
    chk(d[22] && d[17], "R10 rx overflow and full", {30'd0, d[22], d[17]}, 32'd3);
    bus_write(A_EN, 32'd2);
    for (int k = 0; k < 8; k++) begin
      bus_read(A_DATA, d);
      chk(d == 32'hFF, "R6 R10 pin receive", d, 32'hFF);
    end
    bus_read(A_DATA, d);
    chk(d == 32'd0, "R10 empty read returns zero", d, 32'd0);
    bus_read(A_CFG, d);
    chk(d[23] && !d[18], "R10 rx underflow flag", {30'd0, d[23], d[18]}, 32'd2);
    bus_write(A_CFG, mk_cfg(0, 1, 0, 0, 1, 0, 1, 8) | W1C_ALL);
    bus_read(A_CFG, d);
    chk(d[25:22] == 4'd0, "R11 W1C clears all flags", {28'd0, d[25:22]}, 32'd0);

    // R12 enable sequencing
    bus_write(A_EN, 32'd3);
    begin
      int hi = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (sck_o) hi++;
      end
      chk(hi == 0, "R12 disable holds clock", 32'(hi), 32'd0);
    end
    bus_write(A_EN, 32'd1);
    repeat (21) @(negedge clk);
    bus_write(A_EN, 32'd0);
    begin
      logic s0, w0;
      int moved = 0;
      s0 = sck_o; w0 = ws_o;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (sck_o != s0 || ws_o != w0) moved++;
      end
      chk(moved == 0, "R12 clock-enable low freezes", 32'(moved), 32'd0);
      bus_write(A_EN, 32'd1);
      moved = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (sck_o != s0) moved++;
      end
      chk(moved != 0, "R12 clock resumes", 32'(moved), 32'd1);
    end
    bus_write(A_EN, 32'd2);
    repeat (2) @(negedge clk);
    chk({sck_o, ws_o, sd_o} == 3'b010, "R12 power-down parks pins",
        {29'd0, sck_o, ws_o, sd_o}, 32'd2);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule